// File: doc/BRIEF.md
# Multi-Level Priority Interrupt Controller

This block gathers thirteen interrupt requests for an 8051-style processor core and decides which one the core should service next. Source 0 is a power-fail warning. Sources 1 to 6 come from active-low external pins, and each pin can be set to edge or level triggering. Sources 7 to 12 are flags raised by on-chip peripherals. Each source has its own enable bit, and that bit is combined in series with a global enable. The power-fail source is the exception: it is gated only by its own enable.

Each ordinary source carries a programmable 2-bit level from 0 to 3. The power-fail source sits alone on a fixed fifth level, 4, above all of them. When the core accepts a vector, it pulses `irq_ack` while `irq_req` is high. The controller then records the accepted level in an in-service set. It clears the pending flag of an edge-triggered pin, and it strobes a clear line back to any peripheral whose flag is cleared automatically. A pulse on `irq_ret` marks the end of the innermost handler. Only a source at a strictly higher level than every level in service can interrupt a running handler.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `irq_req` is 0, `flag_clr` is all zeros and, with every pin high, `ext_flag` is all zeros.
- R2: A source from 1 to 12 can request only when its `src_en` bit and `glb_en` are both 1. When `glb_en` is 0, only source 0 can still request.
- R3: Source 0 (power-fail) is on level 4. It wins over any pending source at any programmed level, and `glb_en` does not gate it.
- R4: Among pending enabled sources, the one with the highest level in `src_lvl` (0 lowest, 3 highest) is the one presented on `irq_src`.
- R5: When several pending sources share the highest level, the lowest source index wins.
- R6: When `ext_edge[e]` is 1, a high-to-low transition on `ext_pin_n[e]` sets `ext_flag[e]`, and the flag stays set after the pin goes high again. Acknowledging source 1+e clears the flag, and `flag_clr[1+e]` pulses for one cycle after the acknowledge cycle.
- R7: When `ext_edge[e]` is 0, `ext_flag[e]` equals the inverse of the pin. An acknowledge does not clear it, and no `flag_clr` pulse occurs.
- R8: For internal sources 7 to 9, `flag_clr` pulses only the acknowledged source's bit, one cycle after the acknowledge. Sources 10 to 12 and source 0 get no pulse. `flag_clr` never has more than one bit set.
- R9: In the cycle after an accepted acknowledge, `irq_req` is 0. While a level is in service, a new request is raised only for a source whose level is strictly higher than every level in service.
- R10: Each `irq_ret` pulse removes the highest level from the in-service set. A pending source that was blocked becomes requestable once no level at or above its own is in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 6 | Active-low external request pins, sources 1..6 |
| ext_edge | input | 6 | Per-pin trigger mode: 1 edge, 0 level |
| int_flag | input | 6 | Peripheral request flags, sources 7..12 |
| pfail_flag | input | 1 | Power-fail warning flag, source 0 |
| src_en | input | 13 | Per-source enable, bit i for source i |
| glb_en | input | 1 | Global enable for sources 1..12 |
| src_lvl | input | 13x2 | Level per source (entry 0 unused) |
| irq_ack | input | 1 | Core accepts the presented vector |
| irq_ret | input | 1 | Core returns from the innermost handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_src | output | 4 | Index of the requesting source |
| flag_clr | output | 13 | One-cycle automatic clear strobe per source |
| ext_flag | output | 6 | Current pending flag of each external pin |

## Verification
A corrupted in-service set first shows up as a wrong gating decision, and it does so within two cycles. A stuck bit keeps a same-level or lower-level request silent after the matching return. A lost bit lets a same-level source re-raise `irq_req` right after an acknowledge. A wrong edge flag shows on `ext_flag` in the cycle after the pin transition or the acknowledge. A priority or tie-break error shows on `irq_src` one cycle after the inputs settle. The nesting scenario pushes two levels and pops them in turn, so that both the stuck-bit and the lost-bit faults are visible at the ports.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   typedef enum logic {TRIG_LEVEL = 1'b0, TRIG_EDGE = 1'b1} trig_e;
   localparam int PF_IDX = 0;
endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond
   import irq_prio_pkg::*;
#(
   parameter int NUM_EXT = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] pin_n,
   input  logic [NUM_EXT-1:0] edge_mode,
   input  logic [NUM_EXT-1:0] clr,
   output logic [NUM_EXT-1:0] flag
);
   logic [NUM_EXT-1:0] pin_q;
   logic [NUM_EXT-1:0] edge_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= '1;
      else        pin_q <= pin_n;
   end

   for (genvar e = 0; e < NUM_EXT; e++) begin : g_pin
      logic fall;
      assign fall = (edge_mode[e] == TRIG_EDGE) && pin_q[e] && !pin_n[e];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      edge_q[e] <= 1'b0;
         else if (fall)   edge_q[e] <= 1'b1;
         else if (clr[e]) edge_q[e] <= 1'b0;
      end

      assign flag[e] = (edge_mode[e] == TRIG_EDGE) ? edge_q[e] : !pin_n[e];

      // R6: a captured edge persists until its clear strobe
      p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_q[e] && !clr[e]) |=> edge_q[e]);
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int NUM_SRC = 13,
   parameter int SRC_W   = 4,
   parameter int ELVL_W  = 3
) (
   input  logic [NUM_SRC-1:0]             pend,
   input  logic [NUM_SRC-1:0][ELVL_W-1:0] lvl_e,
   output logic                           win_v,
   output logic [SRC_W-1:0]               win_i,
   output logic [ELVL_W-1:0]              win_l
);
   // Scan from the highest index down; ">=" lets a lower index take a tie.
   always_comb begin
      win_v = 1'b0;
      win_i = '0;
      win_l = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend[i] && (!win_v || lvl_e[i] >= win_l)) begin
            win_v = 1'b1;
            win_i = SRC_W'(i);
            win_l = lvl_e[i];
         end
      end
   end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
   parameter int NUM_LVL = 5,
   parameter int ELVL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ELVL_W-1:0] push_lvl,
   input  logic              pop,
   output logic [ELVL_W-1:0] cur_p1
);
   logic [NUM_LVL-1:0] in_svc;
   logic [NUM_LVL-1:0] nxt;

   always_comb begin
      nxt    = in_svc;
      cur_p1 = '0;
      for (int i = 0; i < NUM_LVL; i++)
         if (in_svc[i]) cur_p1 = ELVL_W'(i + 1);
      if (pop && cur_p1 != '0) nxt[cur_p1 - ELVL_W'(1)] = 1'b0;
      if (push) nxt[push_lvl] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_svc <= '0;
      else        in_svc <= nxt;
   end

   // R10: an accepted vector marks its level in service
   p_push_marks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> in_svc[$past(push_lvl)]);
   // R10: a return alone removes exactly one level
   p_pop_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && |in_svc) |=> ($countones(in_svc) == $countones($past(in_svc)) - 1));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter int                 NUM_EXT      = 6,
   parameter int                 NUM_INT      = 6,
   parameter int                 LVL_W        = 2,
   parameter logic [NUM_INT-1:0] AUTO_CLR_INT = 6'b000111,
   localparam int                NUM_SRC      = 1 + NUM_EXT + NUM_INT,
   localparam int                SRC_W        = $clog2(NUM_SRC)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_EXT-1:0]            ext_pin_n,
   input  logic [NUM_EXT-1:0]            ext_edge,
   input  logic [NUM_INT-1:0]            int_flag,
   input  logic                          pfail_flag,
   input  logic [NUM_SRC-1:0]            src_en,
   input  logic                          glb_en,
   input  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl,
   input  logic                          irq_ack,
   input  logic                          irq_ret,
   output logic                          irq_req,
   output logic [SRC_W-1:0]              irq_src,
   output logic [NUM_SRC-1:0]            flag_clr,
   output logic [NUM_EXT-1:0]            ext_flag
);
   localparam int NUM_LVL = (1 << LVL_W) + 1;
   localparam int TOP_LVL = NUM_LVL - 1;
   localparam int ELVL_W  = $clog2(NUM_LVL + 1);

   if (NUM_EXT < 1 || NUM_INT < 1) begin : g_bad_count
      $error("irq_prio_ctrl: need at least one external and one internal source");
   end
   if (LVL_W < 1 || LVL_W > 4) begin : g_bad_lvl
      $error("irq_prio_ctrl: LVL_W out of range");
   end

   logic [NUM_SRC-1:0]             src_flag, pend, auto_en, clr_now, clr_q;
   logic [NUM_SRC-1:0][ELVL_W-1:0] lvl_e;
   logic [NUM_EXT-1:0]             ext_clr;
   logic                           win_v, req_q, ack_ok;
   logic [SRC_W-1:0]               win_i, src_q;
   logic [ELVL_W-1:0]              win_l, lvl_q, cur_p1;

   irq_src_cond #(.NUM_EXT(NUM_EXT)) u_cond (
      .clk(clk), .rst_n(rst_n), .pin_n(ext_pin_n), .edge_mode(ext_edge),
      .clr(ext_clr), .flag(ext_flag));

   assign src_flag = {int_flag, ext_flag, pfail_flag};

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i == PF_IDX) begin : g_pf
         assign lvl_e[i]   = ELVL_W'(TOP_LVL);
         assign pend[i]    = src_flag[i] && src_en[i];
         assign auto_en[i] = 1'b0;
      end else if (i <= NUM_EXT) begin : g_ext
         assign lvl_e[i]   = ELVL_W'(src_lvl[i]);
         assign pend[i]    = src_flag[i] && src_en[i] && glb_en;
         assign auto_en[i] = (ext_edge[i-1] == TRIG_EDGE);
      end else begin : g_int
         assign lvl_e[i]   = ELVL_W'(src_lvl[i]);
         assign pend[i]    = src_flag[i] && src_en[i] && glb_en;
         assign auto_en[i] = AUTO_CLR_INT[i-1-NUM_EXT];
      end
   end

   irq_arbiter #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .ELVL_W(ELVL_W)) u_arb (
      .pend(pend), .lvl_e(lvl_e), .win_v(win_v), .win_i(win_i), .win_l(win_l));

   assign ack_ok  = irq_ack && req_q;
   assign clr_now = ack_ok ? (auto_en & (NUM_SRC'(1) << src_q)) : '0;
   assign ext_clr = clr_now[NUM_EXT:1];

   irq_nest_stack #(.NUM_LVL(NUM_LVL), .ELVL_W(ELVL_W)) u_nest (
      .clk(clk), .rst_n(rst_n), .push(ack_ok), .push_lvl(lvl_q),
      .pop(irq_ret), .cur_p1(cur_p1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         src_q <= '0;
         lvl_q <= '0;
         clr_q <= '0;
      end else begin
         clr_q <= clr_now;
         if (ack_ok) begin
            req_q <= 1'b0;
         end else begin
            req_q <= win_v && ((win_l + ELVL_W'(1)) > cur_p1);
            src_q <= win_i;
            lvl_q <= win_l;
         end
      end
   end

   assign irq_req  = req_q;
   assign irq_src  = src_q;
   assign flag_clr = clr_q;

   // R9: an accepted vector withdraws the request for one cycle
   p_ack_drops_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> !irq_req);
   // R8: at most one clear strobe at a time
   p_clr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flag_clr));
   // R2: with global enable off only the power-fail source is presented
   p_glb_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !$past(glb_en)) |-> (irq_src == SRC_W'(PF_IDX)));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
   logic             clk = 1'b0;
   logic             rst_n;
   logic [5:0]       ext_pin_n, ext_edge, int_flag, ext_flag;
   logic             pfail_flag, glb_en, irq_ack, irq_ret, irq_req;
   logic [12:0]      src_en, flag_clr;
   logic [12:0][1:0] src_lvl;
   logic [3:0]       irq_src;
   int               checks = 0;
   int               failures = 0;

   always #2 clk = ~clk;

   irq_prio_ctrl u_irq_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge(ext_edge),
      .int_flag(int_flag), .pfail_flag(pfail_flag), .src_en(src_en),
      .glb_en(glb_en), .src_lvl(src_lvl), .irq_ack(irq_ack), .irq_ret(irq_ret),
      .irq_req(irq_req), .irq_src(irq_src), .flag_clr(flag_clr), .ext_flag(ext_flag));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic idle();
      ext_pin_n = '1; ext_edge = '0; int_flag = '0; pfail_flag = 1'b0;
      src_en = '1; glb_en = 1'b1; src_lvl = '0; irq_ack = 1'b0; irq_ret = 1'b0;
   endtask

   task automatic ack();
      irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
   endtask

   task automatic ret();
      irq_ret = 1'b1; cyc(1); irq_ret = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 req", irq_req, 0);
      chk("R1 flag_clr", flag_clr, 0);
      chk("R1 ext_flag", ext_flag, 0);
   endtask

   task automatic t_mask();
      glb_en = 1'b0; int_flag[0] = 1'b1; cyc(3);
      chk("R2 global off masks src7", irq_req, 0);
      glb_en = 1'b1; cyc(2);
      chk("R2 global on req", irq_req, 1);
      chk("R2 global on src", irq_src, 7);
      src_en[7] = 1'b0; cyc(2);
      chk("R2 own enable off", irq_req, 0);
      idle(); cyc(2);
   endtask

   task automatic t_pfail();
      glb_en = 1'b0; pfail_flag = 1'b1; cyc(2);
      chk("R3 pfail bypasses global req", irq_req, 1);
      chk("R3 pfail bypasses global src", irq_src, 0);
      glb_en = 1'b1; int_flag[5] = 1'b1; src_lvl[12] = 2'd3; cyc(2);
      chk("R3 pfail beats level 3", irq_src, 0);
      idle(); cyc(2);
   endtask

   task automatic t_level();
      src_lvl[8] = 2'd1; src_lvl[10] = 2'd3; int_flag[1] = 1'b1; int_flag[3] = 1'b1; cyc(2);
      chk("R4 higher level wins", irq_src, 10);
      idle(); cyc(2);
   endtask

   task automatic t_tie();
      src_lvl[9] = 2'd2; src_lvl[11] = 2'd2; int_flag[2] = 1'b1; int_flag[4] = 1'b1; cyc(2);
      chk("R5 tie lower index", irq_src, 9);
      src_lvl[3] = 2'd2; ext_pin_n[2] = 1'b0; cyc(2);
      chk("R5 tie external lower index", irq_src, 3);
      idle(); cyc(2);
   endtask

   task automatic t_edge();
      ext_edge[0] = 1'b1; cyc(1);
      ext_pin_n[0] = 1'b0; cyc(1); ext_pin_n[0] = 1'b1; cyc(3);
      chk("R6 edge flag held", ext_flag[0], 1);
      chk("R6 edge req src", {irq_req, irq_src}, {1'b1, 4'd1});
      ack();
      chk("R6 clear strobe", flag_clr, 13'h0002);
      chk("R6 flag cleared", ext_flag[0], 0);
      chk("R9 req drops after ack", irq_req, 0);
      ret(); idle(); cyc(2);
   endtask

   task automatic t_lvl_ext();
      ext_pin_n[1] = 1'b0; cyc(2);
      chk("R7 level flag follows pin", ext_flag[1], 1);
      chk("R7 level req src", irq_src, 2);
      ack();
      chk("R7 no strobe", flag_clr, 0);
      chk("R7 flag not cleared", ext_flag[1], 1);
      ext_pin_n[1] = 1'b1; cyc(1);
      chk("R7 flag follows pin high", ext_flag[1], 0);
      ret(); idle(); cyc(2);
   endtask

   task automatic t_int_clr();
      int_flag[0] = 1'b1; cyc(2);
      ack();
      chk("R8 auto source strobe", flag_clr, 13'h0080);
      int_flag[0] = 1'b0; ret(); cyc(2);
      int_flag[3] = 1'b1; cyc(2);
      chk("R8 src10 req", irq_src, 10);
      ack();
      chk("R8 non-auto source no strobe", flag_clr, 0);
      int_flag[3] = 1'b0; ret(); idle(); cyc(2);
   endtask

   task automatic t_nest();
      src_lvl[8] = 2'd1; src_lvl[11] = 2'd1; src_lvl[12] = 2'd2;
      int_flag[1] = 1'b1; cyc(2);
      chk("R9 first req src8", irq_src, 8);
      ack(); int_flag[1] = 1'b0;
      int_flag[4] = 1'b1; cyc(3);
      chk("R9 same level blocked", irq_req, 0);
      int_flag[5] = 1'b1; cyc(2);
      chk("R9 higher level preempts", {irq_req, irq_src}, {1'b1, 4'd12});
      ack(); int_flag[5] = 1'b0; cyc(2);
      ret(); cyc(2);
      chk("R10 outer level still blocks", irq_req, 0);
      ret(); cyc(2);
      chk("R10 resumes after pops", {irq_req, irq_src}, {1'b1, 4'd11});
      ack(); int_flag[4] = 1'b0; ret(); idle(); cyc(2);
      chk("R10 idle after unwind", irq_req, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      idle();
      rst_n = 1'b0;
      cyc(3);
      t_reset();
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_mask();
      t_pfail();
      t_level();
      t_tie();
      t_edge();
      t_lvl_ext();
      t_int_clr();
      t_nest();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule